// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Channel

This block is one DMA channel that moves words between a peripheral and one of two target spaces: a fast register-file space or a slower memory space. It holds two descriptor tables. Each table has its own transfer counter and its own address pointer. Both tables always address the same space, which a single control bit selects. Each completed transfer uses the active table: its pointer goes out on the bus, then its counter decrements and its pointer increments. A block ends when that counter reaches zero.

When swap mode is on, the end of a block moves the channel to the other table. The enable bit stays set, so transfers carry on without a gap. The end-of-block flag is still raised, so software can refill the table that has just drained. When swap mode is off, the end of a block clears the enable bit and the channel stops. Requests are taken only at sample points, which fall every fifth clock. A transfer lasts a fixed number of clocks. Memory transfers are also stretched by bus wait states.

Top module: `pp_dma_chan`

## Requirements
- R1: After reset, the bus is idle, the interrupt is low, and the control register reads zero. Control register bits: bit0 enable, bit1 swap, bit2 memory space, bit3 end-of-block flag, bit4 active table. Register addresses: 0 control, 1 count of table 0, 2 pointer of table 0, 3 count of table 1, 4 pointer of table 1.
- R2: A register-file transfer holds `bus_busy` high for exactly 8 cycles, and `bus_wait` has no effect on it.
- R3: A memory transfer holds `bus_busy` high for 16 cycles plus one cycle for each cycle that `bus_wait` is high during it. `bus_mem` is high throughout the transfer.
- R4: Transfers start only at sample points, which are spaced 5 cycles apart. With the request held high, the distance from one start to the next is 5*(L/5+1), where L is the busy length and the division is integer division.
- R5: A request that is high in any cycle of a transfer is kept pending and is served at the first sample point after that transfer. An idle request that falls before a sample point is lost.
- R6: During a transfer, `bus_addr` equals the active pointer. After the transfer, the active count has dropped by 1 and the active pointer has risen by 1.
- R7: With swap on, the end of a block toggles the active table, keeps enable set and sets the end-of-block flag. The next transfer follows at the usual period.
- R8: With swap off, the end of a block clears enable and sets the flag. No further transfer starts while the request stays high.
- R9: The flag drives `eob_irq`. Writing the control register with bit3 set clears the flag, and writing it with bit3 clear leaves the flag unchanged.
- R10: No transfer starts while enable is clear or while the active count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dreq | input | 1 | Peripheral transfer request |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from reg_addr |
| bus_busy | output | 1 | A transfer is in progress |
| bus_addr | output | PTR_W | Transfer address, taken from the active pointer |
| bus_mem | output | 1 | Transfer targets the memory space |
| bus_wait | input | 1 | Wait state, honoured for memory transfers only |
| xfer_done | output | 1 | Last cycle of a transfer |
| eob_irq | output | 1 | End-of-block interrupt request |

## Verification
The hardest case is the moment a swap-mode block ends. The other table has to take over with no lost sample point, and later the channel must stall silently on a drained table and resume once software refills it and turns swap off. The bench keeps the request held high through two tables of different lengths. It checks the address sequence and the start-to-start spacing across the table boundary. It then waits on the empty table before refilling it. A one-cycle request pulse placed in the middle of a transfer checks the pending path, and a sweep over wait counts covers every phase at which a memory transfer can end relative to the sampler.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
   typedef enum logic [2:0] {
      RA_CTRL = 3'd0,
      RA_CNT0 = 3'd1,
      RA_PTR0 = 3'd2,
      RA_CNT1 = 3'd3,
      RA_PTR1 = 3'd4
   } reg_addr_e;

   localparam int CB_EN   = 0;
   localparam int CB_SWAP = 1;
   localparam int CB_MEM  = 2;
   localparam int CB_EOB  = 3;
   localparam int CB_ACT  = 4;
   localparam int CTRL_BITS = 5;
endpackage

// File: rtl/pp_dma_sampler.sv
module pp_dma_sampler #(
   parameter int PERIOD = 5
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int PH_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

   if (PERIOD < 2) begin : g_bad_period
      $error("pp_dma_sampler: PERIOD must be at least 2");
   end

   logic [PH_W-1:0] ph_q;

   assign tick = (ph_q == PH_W'(PERIOD - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ph_q <= '0;
      else if (tick) ph_q <= '0;
      else           ph_q <= ph_q + 1'b1;
   end

   // R4
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/pp_dma_xfer_seq.sv
module pp_dma_xfer_seq #(
   parameter int RF_CYCLES  = 8,
   parameter int MEM_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic mem_i,
   input  logic wait_i,
   output logic busy,
   output logic mem_q,
   output logic done
);
   localparam int MAX_LEN = (MEM_CYCLES > RF_CYCLES) ? MEM_CYCLES : RF_CYCLES;
   localparam int LEN_W   = $clog2(MAX_LEN + 1);

   if (RF_CYCLES < 1 || MEM_CYCLES < 1) begin : g_bad_len
      $error("pp_dma_xfer_seq: transfer lengths must be positive");
   end

   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] last_idx;
   logic             adv;

   assign last_idx = mem_q ? LEN_W'(MEM_CYCLES - 1) : LEN_W'(RF_CYCLES - 1);
   assign adv      = !(mem_q && wait_i);
   assign done     = busy && adv && (cnt_q == last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         mem_q <= 1'b0;
         cnt_q <= '0;
      end else if (start) begin
         busy  <= 1'b1;
         mem_q <= mem_i;
         cnt_q <= '0;
      end else if (busy && adv) begin
         if (cnt_q == last_idx) busy <= 1'b0;
         else                   cnt_q <= cnt_q + 1'b1;
      end
   end

   // R4
   start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);
   // R2
   done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
   // R3
   mem_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> $stable(mem_q));
endmodule

// File: rtl/pp_dma_desc_bank.sv
module pp_dma_desc_bank #(
   parameter int NTAB   = 2,
   parameter int CNT_W  = 8,
   parameter int PTR_W  = 16,
   parameter int DATA_W = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NTAB-1:0]             cnt_we,
   input  logic [NTAB-1:0]             ptr_we,
   input  logic [DATA_W-1:0]           wdata,
   input  logic [$clog2(NTAB)-1:0]     sel,
   input  logic                        step,
   output logic [NTAB-1:0][CNT_W-1:0]  cnt,
   output logic [NTAB-1:0][PTR_W-1:0]  ptr
);
   if (DATA_W < CNT_W || DATA_W < PTR_W) begin : g_bad_w
      $error("pp_dma_desc_bank: DATA_W narrower than a descriptor field");
   end

   for (genvar t = 0; t < NTAB; t++) begin : g_tab
      logic hit;
      assign hit = step && (int'(sel) == t);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          cnt[t] <= '0;
         else if (cnt_we[t])  cnt[t] <= wdata[CNT_W-1:0];
         else if (hit)        cnt[t] <= cnt[t] - 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          ptr[t] <= '0;
         else if (ptr_we[t])  ptr[t] <= wdata[PTR_W-1:0];
         else if (hit)        ptr[t] <= ptr[t] + 1'b1;
      end
   end

   // R6
   step_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> (cnt[sel] != '0));
endmodule

// File: rtl/pp_dma_chan.sv
module pp_dma_chan
   import pp_dma_pkg::*;
#(
   parameter int CNT_W         = 8,
   parameter int PTR_W         = 16,
   parameter int DATA_W        = 16,
   parameter int SAMPLE_PERIOD = 5,
   parameter int RF_CYCLES     = 8,
   parameter int MEM_CYCLES    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dreq,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              bus_busy,
   output logic [PTR_W-1:0]  bus_addr,
   output logic              bus_mem,
   input  logic              bus_wait,
   output logic              xfer_done,
   output logic              eob_irq
);
   localparam int NTAB = 2;

   if (DATA_W < CTRL_BITS) begin : g_bad_data
      $error("pp_dma_chan: DATA_W too narrow for the control register");
   end

   logic en_q, swap_q, space_q, eob_q, act_q, pend_q;
   logic tick, start, blk_end, ctrl_wr;
   logic [NTAB-1:0]            cnt_we, ptr_we;
   logic [NTAB-1:0][CNT_W-1:0] cnt;
   logic [NTAB-1:0][PTR_W-1:0] ptr;
   logic [CNT_W-1:0]           act_cnt;

   pp_dma_sampler #(.PERIOD(SAMPLE_PERIOD)) u_smp (
      .clk(clk), .rst_n(rst_n), .tick(tick));

   pp_dma_xfer_seq #(.RF_CYCLES(RF_CYCLES), .MEM_CYCLES(MEM_CYCLES)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .mem_i(space_q),
      .wait_i(bus_wait), .busy(bus_busy), .mem_q(bus_mem), .done(xfer_done));

   pp_dma_desc_bank #(.NTAB(NTAB), .CNT_W(CNT_W), .PTR_W(PTR_W), .DATA_W(DATA_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .cnt_we(cnt_we), .ptr_we(ptr_we),
      .wdata(reg_wdata), .sel(act_q), .step(xfer_done), .cnt(cnt), .ptr(ptr));

   assign ctrl_wr   = reg_we && (reg_addr == RA_CTRL);
   assign cnt_we    = {reg_we && (reg_addr == RA_CNT1), reg_we && (reg_addr == RA_CNT0)};
   assign ptr_we    = {reg_we && (reg_addr == RA_PTR1), reg_we && (reg_addr == RA_PTR0)};
   assign act_cnt   = cnt[act_q];
   assign bus_addr  = ptr[act_q];
   assign eob_irq   = eob_q;
   assign start     = tick && en_q && !bus_busy && (act_cnt != '0) && (dreq || pend_q);
   assign blk_end   = xfer_done && (act_cnt == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         swap_q  <= 1'b0;
         space_q <= 1'b0;
         eob_q   <= 1'b0;
         act_q   <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            en_q    <= reg_wdata[CB_EN];
            swap_q  <= reg_wdata[CB_SWAP];
            space_q <= reg_wdata[CB_MEM];
            if (reg_wdata[CB_EOB]) eob_q <= 1'b0;
         end
         if (blk_end) begin
            eob_q <= 1'b1;
            if (swap_q) act_q <= ~act_q;
            else        en_q  <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   pend_q <= 1'b0;
      else if (start)               pend_q <= 1'b0;
      else if (blk_end && !swap_q)  pend_q <= 1'b0;
      else if (bus_busy && dreq)    pend_q <= 1'b1;
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_CTRL: begin
            reg_rdata[CB_EN]   = en_q;
            reg_rdata[CB_SWAP] = swap_q;
            reg_rdata[CB_MEM]  = space_q;
            reg_rdata[CB_EOB]  = eob_q;
            reg_rdata[CB_ACT]  = act_q;
         end
         RA_CNT0: reg_rdata[CNT_W-1:0] = cnt[0];
         RA_PTR0: reg_rdata[PTR_W-1:0] = ptr[0];
         RA_CNT1: reg_rdata[CNT_W-1:0] = cnt[1];
         RA_PTR1: reg_rdata[PTR_W-1:0] = ptr[1];
         default: reg_rdata = '0;
      endcase
   end

   // R4
   start_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_busy) |-> $past(tick));
   // R9
   eob_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blk_end |=> eob_irq);
   // R8
   noswap_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_end && !swap_q) |=> !en_q);
   // R7
   swap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_end && swap_q && !ctrl_wr) |=> (en_q && (act_q != $past(act_q))));
   // R10
   no_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q || act_cnt == '0) |=> !$rose(bus_busy));
endmodule

// File: tb/sim_pp_dma_chan.sv
module sim_pp_dma_chan;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dreq = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [15:0] reg_wdata = 16'd0;
   logic [15:0] reg_rdata;
   logic        bus_busy;
   logic [15:0] bus_addr;
   logic        bus_mem;
   logic        bus_wait = 1'b0;
   logic        xfer_done;
   logic        eob_irq;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   int nst = 0;
   int w_cfg = 0;
   int wcnt = 0;
   int cur_len = 0;
   logic busy_prev = 1'b0;
   int          st_cyc  [16];
   int          st_len  [16];
   logic [15:0] st_addr [16];
   logic        st_mem  [16];

   always #10 clk = ~clk;

   pp_dma_chan u0 (
      .clk(clk), .rst_n(rst_n), .dreq(dreq), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_busy(bus_busy),
      .bus_addr(bus_addr), .bus_mem(bus_mem), .bus_wait(bus_wait),
      .xfer_done(xfer_done), .eob_irq(eob_irq));

   // transfer monitor and wait-state driver
   always @(negedge clk) begin
      cyc++;
      if (bus_busy && !busy_prev && nst < 16) begin
         st_cyc[nst]  = cyc;
         st_addr[nst] = bus_addr;
         st_mem[nst]  = bus_mem;
         nst++;
         wcnt = 0;
         cur_len = 0;
      end
      if (bus_busy) begin
         cur_len++;
         if (wcnt < w_cfg) begin bus_wait = 1'b1; wcnt++; end
         else bus_wait = 1'b0;
      end else begin
         bus_wait = 1'b0;
         if (busy_prev && nst > 0) st_len[nst-1] = cur_len;
      end
      busy_prev = bus_busy;
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [15:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(3'd0, d);
      chk("R1 ctrl", int'(d), 0);
      chk("R1 busy", int'(bus_busy), 0);
      chk("R1 irq", int'(eob_irq), 0);

      // R2/R4/R6/R8: register-file block, swap off, wait ignored
      nst = 0; w_cfg = 3;
      wr(3'd2, 16'h0040);
      wr(3'd1, 16'd4);
      wr(3'd0, 16'h0001);
      dreq = 1'b1;
      wait (eob_irq);
      repeat (40) @(negedge clk);
      chk("R8 count", nst, 4);
      for (int i = 0; i < 4; i++) begin
         chk("R2 len", st_len[i], 8);
         chk("R6 addr", int'(st_addr[i]), 'h40 + i);
         if (i > 0) chk("R4 period rf", st_cyc[i] - st_cyc[i-1], 10);
      end
      rd(3'd0, d); chk("R8 ctrl", int'(d), 'h08);
      rd(3'd1, d); chk("R6 cnt0", int'(d), 0);
      rd(3'd2, d); chk("R6 ptr0", int'(d), 'h44);
      chk("R10 disabled idle", int'(bus_busy), 0);
      wr(3'd0, 16'h0000);
      chk("R9 keep irq", int'(eob_irq), 1);
      wr(3'd0, 16'h0008);
      chk("R9 clear irq", int'(eob_irq), 0);

      // R3/R4: memory transfers over a sweep of wait counts
      for (int w = 0; w <= 6; w++) begin
         nst = 0; w_cfg = w;
         wr(3'd2, 16'(w * 16));
         wr(3'd1, 16'd2);
         wr(3'd0, 16'h0005);
         wait (eob_irq);
         repeat (3) @(negedge clk);
         chk("R3 len0", st_len[0], 16 + w);
         chk("R3 len1", st_len[1], 16 + w);
         chk("R3 mem", int'(st_mem[0]), 1);
         chk("R4 period mem", st_cyc[1] - st_cyc[0], 5 * ((16 + w) / 5 + 1));
         chk("R6 addr mem", int'(st_addr[1]), w * 16 + 1);
         wr(3'd0, 16'h0008);
      end

      // R5: pending request
      dreq = 1'b0; w_cfg = 0; nst = 0;
      wr(3'd2, 16'h0500);
      wr(3'd1, 16'd3);
      wr(3'd0, 16'h0001);
      dreq = 1'b1;
      wait (nst == 1);
      dreq = 1'b0;
      repeat (40) @(negedge clk);
      chk("R5 no lost pending", nst, 1);
      dreq = 1'b1;
      wait (nst == 2);
      dreq = 1'b0;
      repeat (2) @(negedge clk);
      dreq = 1'b1;
      @(negedge clk);
      dreq = 1'b0;
      wait (nst == 3);
      chk("R5 pending served", st_cyc[2] - st_cyc[1], 10);
      wait (eob_irq);
      wr(3'd0, 16'h0008);

      // R10: enabled but active count zero
      wr(3'd0, 16'h0001);
      dreq = 1'b1;
      repeat (30) @(negedge clk);
      chk("R10 zero count", nst, 3);
      dreq = 1'b0;
      wr(3'd0, 16'h0000);

      // R7: swap mode across two tables
      nst = 0;
      wr(3'd2, 16'h0100);
      wr(3'd1, 16'd3);
      wr(3'd4, 16'h0200);
      wr(3'd3, 16'd2);
      wr(3'd0, 16'h0003);
      dreq = 1'b1;
      wait (nst == 4);
      rd(3'd0, d);
      chk("R7 active table 1", int'(d[4]), 1);
      chk("R7 enable kept", int'(d[0]), 1);
      chk("R7 irq", int'(eob_irq), 1);
      wait (nst == 5);
      repeat (40) @(negedge clk);
      chk("R7 stall on empty", nst, 5);
      chk("R7 addr a", int'(st_addr[2]), 'h102);
      chk("R7 addr b", int'(st_addr[3]), 'h200);
      chk("R7 addr c", int'(st_addr[4]), 'h201);
      chk("R7 no gap", st_cyc[3] - st_cyc[2], 10);
      rd(3'd0, d);
      chk("R7 ctrl back on 0", int'(d), 'h0B);
      wr(3'd2, 16'h0300);
      wr(3'd0, 16'h0009);
      chk("R9 clear in swap", int'(eob_irq), 0);
      wr(3'd1, 16'd2);
      wait (eob_irq);
      repeat (40) @(negedge clk);
      chk("R8 after refill", nst, 7);
      chk("R6 refill addr", int'(st_addr[6]), 'h301);
      rd(3'd0, d);
      chk("R8 stopped", int'(d), 'h08);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule